// File: doc/BRIEF.md
# Serial Command Decoder for a Character Display Controller

The block takes 16-bit command frames from a host over a three-wire serial link. The link has an active-low select, a serial clock and one data line. The data line is split here into an input, an output and an output enable. The decoder keeps the display control flags, a 4-bit contrast code, a display offset and an address counter. It turns each accepted frame into a register update or into a single write on a shared memory write port. That port serves three stores: character codes, marks and glyph patterns. One opcode family sends key-matrix data back on the data line during the second half of the same frame.

The serial lines are sampled by the system clock through synchronisers. A frame is acted on a fixed number of cycles after its last bit. Slow commands hold a busy flag for a number of oscillator ticks, counted on `osc_tick_i`. Any frame that completes while busy is dropped. The clear command fills all 30 character cells with the blank code, one cell per clock.

Top module: `scmd_decoder`

## Requirements
- R1: A frame begins with cs_ni low. Bits are taken MSB first on rising sclk_i edges. The first byte is the opcode and the second is the operand. The frame acts once, at its 16th bit, and any further bits before cs_ni rises are ignored.
- R2: If cs_ni rises before 16 bits have been taken, the partial frame is discarded and changes no state.
- R3: The control opcodes act as follows, and any undefined opcode has no effect:
  - 0x88: operand bit1 sets incr_o and bit0 sets shift_o.
  - 0x89: operand bits 2..0 set disp_on_o, cursor_o and blink_o.
  - 0x8C: operand bits 3..0 set contrast_o.
  - 0x8E: operand bits 3..0 set boost_o, duty_o, key_scan_o and power_down_o.
- R4: Opcode bits 7..2 equal to 101001 mark a key read, and opcode bits 1..0 select a row. During bits 8..15, sdata_oe_o is high and sdata_o sends, MSB first, a byte whose bits 7..6 are 0 and whose bits 5..0 are key_rows_i[row*6+5 : row*6]. The first reply bit is valid after the 8th rising edge, and each later bit follows the next rising edge. At all other times sdata_oe_o and sdata_o are 0.
- R5: Three opcodes load the address counter:
  - 0x93 sets addr_o to operand bits 6..0 and targets the character/mark space.
  - 0x90 sets addr_o to the full operand and targets the pattern space.
  - 0x91 sets addr_o to 0 and targets the character/mark space.
- R6: Opcode 0x98 writes according to the target and the address. The mem_sel_o codes are 0 for character, 1 for mark and 2 for pattern.
  - Pattern target: a write of the operand with sel 2 when addr_o is not 0xFF.
  - Character/mark target, address 0x40..0x53: a write of operand bits 4..0 with sel 1.
  - Character/mark target, address bits 7..4 below 3 and bits 3..0 below 10: a write of the operand with sel 0.
  - Any other address: no write.
- R7: After every 0x98 frame, addr_o steps by +1 when incr_o is 1 and by -1 when it is 0, whether or not a write took place. The step wraps in 7 bits for the character/mark target and in 8 bits for the pattern target.
- R8: Opcode 0x92 steps addr_o by +1 (operand bit0 = 1) or -1 (bit0 = 0), with the same wrap as R7. Opcode 0x8A steps disp_ofs_o by +1 or -1 the same way, wrapping within 0..9.
- R9: Opcode 0x99 sets addr_o to 0, sets incr_o, and targets the character/mark space. It then issues 30 writes with sel 0 and data 0x20, covering 0x00-0x09, 0x10-0x19 and 0x20-0x29 in ascending order.
- R10: busy_o rises when a clear or write frame is accepted. It falls after 110 ticks for a clear (and not before the fill ends) or 7 ticks for a write. A frame that completes while busy_o is high, including in the cycle the last tick lands, is ignored; a key read made while busy sends no reply.
- R11: After reset, the outputs read as follows:
  - disp_on_o, cursor_o, blink_o, shift_o, boost_o and power_down_o are 0.
  - incr_o, duty_o and key_scan_o are 1.
  - contrast_o, addr_o and disp_ofs_o are 0.
  - busy_o, mem_we_o and sdata_oe_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial frame select, active low |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data from host |
| sdata_o | output | 1 | Serial data to host |
| sdata_oe_o | output | 1 | Drive enable for sdata_o |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator period |
| key_rows_i | input | 24 | Key levels, 6 per row, row 0 lowest |
| busy_o | output | 1 | Slow command in progress |
| mem_we_o | output | 1 | Memory write strobe |
| mem_sel_o | output | 2 | Target store: 0 char, 1 mark, 2 pattern |
| mem_addr_o | output | 8 | Write address |
| mem_wdata_o | output | 8 | Write data |
| disp_on_o | output | 1 | Display enable flag |
| cursor_o | output | 1 | Cursor flag |
| blink_o | output | 1 | Blink flag |
| incr_o | output | 1 | Address step direction, 1 = up |
| shift_o | output | 1 | Entry shift flag |
| boost_o | output | 1 | Drive voltage select flag |
| duty_o | output | 1 | Duty select flag |
| key_scan_o | output | 1 | Key scan enable flag |
| power_down_o | output | 1 | Power-down flag |
| contrast_o | output | 4 | Contrast code |
| addr_o | output | 8 | Address counter |
| disp_ofs_o | output | 4 | Display offset, 0..9 |

## Verification
Two events can coincide in one cycle: a frame completing, and the final oscillator tick that ends the busy window. The bench lines up that last tick with the exact clock on which the decoder acts on a write frame. The frame must be dropped: no entry appears in the write log, and addr_o does not move. A write sent straight afterwards must be accepted. The clear fill can also meet a new frame, since its 30 writes share the same write port. This is judged by checking that the write log holds exactly the 30 blank writes in order.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
  typedef enum logic [1:0] {
    MEM_CHAR = 2'd0,
    MEM_MARK = 2'd1,
    MEM_PAT  = 2'd2
  } mem_sel_e;

  localparam logic [7:0] OP_CLEAR  = 8'h99;
  localparam logic [7:0] OP_HOME   = 8'h91;
  localparam logic [7:0] OP_ENTRY  = 8'h88;
  localparam logic [7:0] OP_DISP   = 8'h89;
  localparam logic [7:0] OP_ASHIFT = 8'h92;
  localparam logic [7:0] OP_DSHIFT = 8'h8A;
  localparam logic [7:0] OP_CONTR  = 8'h8C;
  localparam logic [7:0] OP_MODE   = 8'h8E;
  localparam logic [7:0] OP_SET_DM = 8'h93;
  localparam logic [7:0] OP_SET_CG = 8'h90;
  localparam logic [7:0] OP_WRITE  = 8'h98;
  localparam logic [5:0] OP_KEY_HI = 6'b101001;
endpackage

// File: rtl/scmd_serial_rx.sv
module scmd_serial_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_W     = 16,
  localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  output logic               active_o,
  output logic               rise_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               half_o,
  output logic               frame_valid_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(FRAME_W / 2 - 1);

  logic [SYNC_STAGES-1:0] cs_s, sck_s, dat_s;
  logic                   sck_prev;
  logic [CNT_W-1:0]       cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_s  <= '1;
      sck_s <= '0;
      dat_s <= '0;
    end else begin
      cs_s  <= {cs_s[SYNC_STAGES-2:0], cs_ni};
      sck_s <= {sck_s[SYNC_STAGES-2:0], sclk_i};
      dat_s <= {dat_s[SYNC_STAGES-2:0], sdata_i};
    end
  end

  assign active_o = ~cs_s[SYNC_STAGES-1];
  assign rise_o   = active_o & sck_s[SYNC_STAGES-1] & ~sck_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev      <= 1'b0;
      cnt_q         <= '0;
      frame_o       <= '0;
      half_o        <= 1'b0;
      frame_valid_o <= 1'b0;
    end else begin
      sck_prev      <= sck_s[SYNC_STAGES-1];
      half_o        <= 1'b0;
      frame_valid_o <= 1'b0;
      if (!active_o) begin
        cnt_q <= '0;
      end else if (rise_o && cnt_q != CNT_FULL) begin
        frame_o <= {frame_o[FRAME_W-2:0], dat_s[SYNC_STAGES-1]};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_HALF) half_o <= 1'b1;
        if (cnt_q == CNT_LAST) frame_valid_o <= 1'b1;
      end
    end
  end

  // one execution per frame
  assert_frame_once_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  // no frame completes once select has been released
  assert_abort_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !$past(active_o)) |-> !frame_valid_o);
endmodule

// File: rtl/scmd_busy_timer.sv
module scmd_busy_timer #(
  parameter int MAX_TICKS = 110,
  localparam int TW       = $clog2(MAX_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          busy_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= MAX_TICKS);
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/scmd_fill.sv
module scmd_fill #(
  parameter int LINES       = 3,
  parameter int LINE_LEN    = 10,
  parameter int LINE_STRIDE = 16,
  parameter int AW          = 8,
  localparam int LNW        = $clog2(LINES + 1),
  localparam int CLW        = $clog2(LINE_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          active_o,
  output logic [AW-1:0] addr_o
);
  logic [LNW-1:0] line_q;
  logic [CLW-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      line_q   <= '0;
      col_q    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      line_q   <= '0;
      col_q    <= '0;
    end else if (active_o) begin
      if (int'(col_q) == LINE_LEN - 1) begin
        col_q  <= '0;
        line_q <= line_q + 1'b1;
        if (int'(line_q) == LINES - 1) active_o <= 1'b0;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign addr_o = AW'(int'(line_q) * LINE_STRIDE + int'(col_q));

  assert_fill_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (int'(col_q) < LINE_LEN && int'(line_q) < LINES));
endmodule

// File: rtl/scmd_decoder.sv
module scmd_decoder
  import scmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_TICKS   = 110,
  parameter int WR_TICKS    = 7,
  parameter int LINES       = 3,
  parameter int LINE_LEN    = 10,
  parameter int LINE_STRIDE = 16,
  parameter int MARK_BASE   = 64,
  parameter int MARK_CNT    = 20,
  parameter int MARK_DW     = 5,
  parameter int PAT_DEPTH   = 255,
  parameter int KEY_ROWS    = 4,
  parameter int KEY_COLS    = 6,
  parameter int CW          = 4,
  parameter logic [7:0] FILL_CODE = 8'h20,
  localparam int FRAME_W    = 16,
  localparam int BW         = FRAME_W / 2,
  localparam int AW         = 8,
  localparam int DM_AW      = 7,
  localparam int TW         = $clog2(CLR_TICKS + 1),
  localparam int OFS_W      = $clog2(LINE_LEN),
  localparam int RSEL_W     = $clog2(KEY_ROWS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cs_ni,
  input  logic                         sclk_i,
  input  logic                         sdata_i,
  output logic                         sdata_o,
  output logic                         sdata_oe_o,
  input  logic                         osc_tick_i,
  input  logic [KEY_ROWS*KEY_COLS-1:0] key_rows_i,
  output logic                         busy_o,
  output logic                         mem_we_o,
  output logic [1:0]                   mem_sel_o,
  output logic [AW-1:0]                mem_addr_o,
  output logic [BW-1:0]                mem_wdata_o,
  output logic                         disp_on_o,
  output logic                         cursor_o,
  output logic                         blink_o,
  output logic                         incr_o,
  output logic                         shift_o,
  output logic                         boost_o,
  output logic                         duty_o,
  output logic                         key_scan_o,
  output logic                         power_down_o,
  output logic [CW-1:0]                contrast_o,
  output logic [AW-1:0]                addr_o,
  output logic [OFS_W-1:0]             disp_ofs_o
);
  logic               rx_active, rx_rise, rx_half, rx_valid;
  logic [FRAME_W-1:0] rx_frame;
  logic [BW-1:0]      op, arg;
  logic               acc;
  logic               tmr_load, tmr_busy;
  logic [TW-1:0]      tmr_val;
  logic               fill_start, fill_active;
  logic [AW-1:0]      fill_addr;
  logic [AW-1:0]      ac_q;
  logic               pat_q;
  logic               in_char, in_mark, in_pat, wr_ok;
  mem_sel_e           wr_sel, mem_sel_q;
  logic [KEY_COLS-1:0] row_keys;
  logic [BW-1:0]      reply_q;
  logic               reply_on_q;

  scmd_serial_rx #(.SYNC_STAGES(SYNC_STAGES), .FRAME_W(FRAME_W)) u_rx (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdata_i,
    .active_o(rx_active), .rise_o(rx_rise), .frame_o(rx_frame),
    .half_o(rx_half), .frame_valid_o(rx_valid)
  );

  assign op  = rx_frame[FRAME_W-1:BW];
  assign arg = rx_frame[BW-1:0];
  // busy is judged from registered state: a frame landing on the last tick is dropped
  assign acc = rx_valid & ~busy_o;

  assign tmr_load   = acc && (op == OP_CLEAR || op == OP_WRITE);
  assign tmr_val    = (op == OP_CLEAR) ? TW'(CLR_TICKS) : TW'(WR_TICKS);
  assign fill_start = acc && (op == OP_CLEAR);

  scmd_busy_timer #(.MAX_TICKS(CLR_TICKS)) u_busy (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val),
    .tick_i(osc_tick_i), .busy_o(tmr_busy)
  );

  scmd_fill #(.LINES(LINES), .LINE_LEN(LINE_LEN), .LINE_STRIDE(LINE_STRIDE), .AW(AW)) u_fill (
    .clk_i, .rst_ni, .start_i(fill_start), .active_o(fill_active), .addr_o(fill_addr)
  );

  assign busy_o = tmr_busy | fill_active;

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, logic up, logic pat);
    logic [AW-1:0] n;
    n = up ? a + 1'b1 : a - 1'b1;
    if (!pat) n[AW-1:DM_AW] = '0;
    return n;
  endfunction

  always_comb begin
    in_char = (int'(ac_q) / LINE_STRIDE < LINES) && (int'(ac_q) % LINE_STRIDE < LINE_LEN);
    in_mark = (int'(ac_q) >= MARK_BASE) && (int'(ac_q) < MARK_BASE + MARK_CNT);
    in_pat  = int'(ac_q) < PAT_DEPTH;
    if (pat_q) begin
      wr_ok  = in_pat;
      wr_sel = MEM_PAT;
    end else if (in_mark) begin
      wr_ok  = 1'b1;
      wr_sel = MEM_MARK;
    end else begin
      wr_ok  = in_char;
      wr_sel = MEM_CHAR;
    end
  end

  // control registers and address counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_on_o    <= 1'b0;
      cursor_o     <= 1'b0;
      blink_o      <= 1'b0;
      incr_o       <= 1'b1;
      shift_o      <= 1'b0;
      boost_o      <= 1'b0;
      duty_o       <= 1'b1;
      key_scan_o   <= 1'b1;
      power_down_o <= 1'b0;
      contrast_o   <= '0;
      ac_q         <= '0;
      pat_q        <= 1'b0;
      disp_ofs_o   <= '0;
    end else if (acc) begin
      case (op)
        OP_CLEAR: begin
          ac_q   <= '0;
          incr_o <= 1'b1;
          pat_q  <= 1'b0;
        end
        OP_HOME: begin
          ac_q  <= '0;
          pat_q <= 1'b0;
        end
        OP_ENTRY:  {incr_o, shift_o} <= arg[1:0];
        OP_DISP:   {disp_on_o, cursor_o, blink_o} <= arg[2:0];
        OP_ASHIFT: ac_q <= step_addr(ac_q, arg[0], pat_q);
        OP_DSHIFT: begin
          if (arg[0])
            disp_ofs_o <= (int'(disp_ofs_o) == LINE_LEN - 1) ? '0 : disp_ofs_o + 1'b1;
          else
            disp_ofs_o <= (disp_ofs_o == '0) ? OFS_W'(LINE_LEN - 1) : disp_ofs_o - 1'b1;
        end
        OP_CONTR:  contrast_o <= arg[CW-1:0];
        OP_MODE:   {boost_o, duty_o, key_scan_o, power_down_o} <= arg[3:0];
        OP_SET_DM: begin
          ac_q  <= AW'(arg[DM_AW-1:0]);
          pat_q <= 1'b0;
        end
        OP_SET_CG: begin
          ac_q  <= arg;
          pat_q <= 1'b1;
        end
        OP_WRITE:  ac_q <= step_addr(ac_q, incr_o, pat_q);
        default: ;
      endcase
    end
  end

  assign addr_o = ac_q;

  // shared write port: fill has priority, frames cannot arrive during it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_sel_q   <= MEM_CHAR;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (fill_active) begin
        mem_we_o    <= 1'b1;
        mem_sel_q   <= MEM_CHAR;
        mem_addr_o  <= fill_addr;
        mem_wdata_o <= FILL_CODE;
      end else if (acc && op == OP_WRITE && wr_ok) begin
        mem_we_o    <= 1'b1;
        mem_sel_q   <= wr_sel;
        mem_addr_o  <= ac_q;
        mem_wdata_o <= (wr_sel == MEM_MARK) ? BW'(arg[MARK_DW-1:0]) : arg;
      end
    end
  end

  assign mem_sel_o = mem_sel_q;

  // key reply during second byte
  always_comb row_keys = key_rows_i[int'(rx_frame[RSEL_W-1:0]) * KEY_COLS +: KEY_COLS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reply_on_q <= 1'b0;
      reply_q    <= '0;
    end else if (!rx_active) begin
      reply_on_q <= 1'b0;
      reply_q    <= '0;
    end else if (rx_half && !busy_o && rx_frame[BW-1:BW-6] == OP_KEY_HI) begin
      reply_on_q <= 1'b1;
      reply_q    <= BW'(row_keys);
    end else if (reply_on_q && rx_rise) begin
      reply_q <= {reply_q[BW-2:0], 1'b0};
    end
  end

  assign sdata_oe_o = reply_on_q;
  assign sdata_o    = reply_on_q & reply_q[BW-1];

  assert_reply_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sdata_oe_o) && KEY_COLS < BW) |-> !sdata_o);
  assert_mark_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_sel_q == MEM_MARK) |->
      (int'(mem_addr_o) >= MARK_BASE && int'(mem_addr_o) < MARK_BASE + MARK_CNT));
  assert_char_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_sel_q == MEM_CHAR) |->
      (int'(mem_addr_o) / LINE_STRIDE < LINES && int'(mem_addr_o) % LINE_STRIDE < LINE_LEN));
  assert_write_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && busy_o) |=> $stable(ac_q));
  assert_clear_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_active) |-> (ac_q == '0 && incr_o));
endmodule

// File: tb/scmd_decoder_bench.sv
module scmd_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, tick = 1'b0;
  logic [23:0] keys = {6'h0C, 6'h33, 6'h2A, 6'h15};
  logic sdo, sdo_oe, busy, we;
  logic [1:0] sel;
  logic [7:0] maddr, mdata, addr;
  logic disp_on, cursor, blink, incr, shift, boost, duty, key_scan, pdn;
  logic [3:0] contrast, ofs;
  int checks = 0, failures = 0;
  bit done = 0;
  int log_n = 0;
  logic [1:0] log_sel [0:63];
  logic [7:0] log_addr [0:63];
  logic [7:0] log_data [0:63];

  always #4 clk = ~clk;

  scmd_decoder u_scmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdata_i(sdi),
    .sdata_o(sdo), .sdata_oe_o(sdo_oe), .osc_tick_i(tick), .key_rows_i(keys),
    .busy_o(busy), .mem_we_o(we), .mem_sel_o(sel), .mem_addr_o(maddr), .mem_wdata_o(mdata),
    .disp_on_o(disp_on), .cursor_o(cursor), .blink_o(blink), .incr_o(incr), .shift_o(shift),
    .boost_o(boost), .duty_o(duty), .key_scan_o(key_scan), .power_down_o(pdn),
    .contrast_o(contrast), .addr_o(addr), .disp_ofs_o(ofs)
  );

  always @(posedge clk) if (we && log_n < 64) begin
    log_sel[log_n]  <= sel;
    log_addr[log_n] <= maddr;
    log_data[log_n] <= mdata;
    log_n <= log_n + 1;
  end

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bits(input logic [19:0] f, input int nbits, input bit tick_last);
    cs_n = 1'b0;
    clk_n(3);
    for (int i = 0; i < nbits; i++) begin
      sdi = f[nbits-1-i];
      sclk = 1'b0;
      clk_n(3);
      sclk = 1'b1;
      if (tick_last && i == nbits - 1) begin
        clk_n(3); tick = 1'b1; clk_n(1); tick = 1'b0; clk_n(2);
      end else clk_n(3);
    end
    sclk = 1'b0;
    clk_n(3);
    cs_n = 1'b1;
    clk_n(6);
  endtask

  task automatic send(input logic [15:0] f);
    send_bits({4'h0, f}, 16, 1'b0);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin tick = 1'b1; clk_n(1); tick = 1'b0; clk_n(1); end
  endtask

  task automatic wr(input logic [7:0] d);
    send({8'h98, d});
    ticks(7);
  endtask

  task automatic t_reset;
    chk("R11", "disp/cur/blink", {disp_on, cursor, blink}, 0);
    chk("R11", "incr/shift", {incr, shift}, 2);
    chk("R11", "boost/duty/key/pd", {boost, duty, key_scan, pdn}, 4'b0110);
    chk("R11", "contrast", contrast, 0);
    chk("R11", "addr/ofs", {addr, ofs}, 0);
    chk("R11", "busy/we/oe", {busy, we, sdo_oe}, 0);
  endtask

  task automatic t_control;
    send(16'h8801);
    chk("R3", "entry incr/shift", {incr, shift}, 2'b01);
    send(16'h8802);
    send(16'h8907);
    chk("R3", "on/off flags", {disp_on, cursor, blink}, 3'b111);
    send(16'h8CA5);
    chk("R3", "contrast", contrast, 5);
    send(16'h8E0A);
    chk("R3", "mode flags", {boost, duty, key_scan, pdn}, 4'b1010);
    send(16'hFFFF);
    chk("R3", "undefined opcode", {disp_on, cursor, blink, incr, shift, boost, duty, key_scan, pdn, contrast, addr},
        {3'b111, 2'b10, 4'b1010, 4'h5, 8'h00});
  endtask

  task automatic t_frame;
    send_bits(20'h8C3F >> 6, 10, 1'b0);
    chk("R2", "partial frame discarded", contrast, 5);
    send_bits(20'h8C03F, 20, 1'b0);
    chk("R1", "extra bits ignored", contrast, 3);
    chk("R1", "no write from extra bits", log_n, 0);
  endtask

  task automatic t_write_mark_busy;
    int b;
    b = log_n;
    send(16'h9345);
    chk("R5", "set char/mark addr", addr, 8'h45);
    send(16'h98FF);
    chk("R6", "mark write count", log_n - b, 1);
    chk("R6", "mark write sel/addr/data", {log_sel[b], log_addr[b], log_data[b]}, {2'd1, 8'h45, 8'h1F});
    chk("R7", "increment after write", addr, 8'h46);
    chk("R10", "busy after write", busy, 1);
    ticks(6);
    chk("R10", "busy after 6 ticks", busy, 1);
    ticks(1);
    chk("R10", "busy clear after 7 ticks", busy, 0);
  endtask

  task automatic t_char_and_wrap;
    int b;
    b = log_n;
    send(16'h8800);
    send(16'h9310);
    wr(8'h41);
    chk("R6", "char write", {log_sel[b], log_addr[b], log_data[b]}, {2'd0, 8'h10, 8'h41});
    chk("R7", "decrement after write", addr, 8'h0F);
    send(16'h930A);
    wr(8'h42);
    chk("R6", "no write past line end", log_n - b, 1);
    chk("R7", "step without write", addr, 8'h09);
    send(16'h8802);
    send(16'h937F);
    wr(8'h43);
    chk("R6", "no write at 0x7F", log_n - b, 1);
    chk("R7", "7-bit wrap", addr, 8'h00);
    send(16'h90FE);
    chk("R5", "set pattern addr", addr, 8'hFE);
    wr(8'hA5);
    chk("R6", "pattern write", {log_sel[b+1], log_addr[b+1], log_data[b+1]}, {2'd2, 8'hFE, 8'hA5});
    wr(8'h5A);
    chk("R6", "no pattern write at 0xFF", log_n - b, 2);
    chk("R7", "8-bit wrap", addr, 8'h00);
    send(16'h9155);
    chk("R5", "home", addr, 8'h00);
  endtask

  task automatic t_shifts;
    send(16'h9310);
    send(16'h9201);
    chk("R8", "address shift up", addr, 8'h11);
    send(16'h9200);
    send(16'h9200);
    chk("R8", "address shift down", addr, 8'h0F);
    send(16'h8A00);
    chk("R8", "display shift wraps low", ofs, 9);
    send(16'h8A01);
    chk("R8", "display shift wraps high", ofs, 0);
  endtask

  task automatic t_busy_collision;
    int b;
    send(16'h9320);
    b = log_n;
    send(16'h9811);
    send(16'h9822);
    chk("R10", "write while busy ignored", log_n - b, 1);
    chk("R10", "addr held while busy", addr, 8'h21);
    ticks(6);
    send_bits({4'h0, 16'h9833}, 16, 1'b1);
    chk("R10", "frame on last tick ignored", log_n - b, 1);
    chk("R10", "addr held on last tick", addr, 8'h21);
    chk("R10", "busy released", busy, 0);
    wr(8'h44);
    chk("R10", "next frame accepted", {log_addr[b+1], log_data[b+1]}, {8'h21, 8'h44});
  endtask

  task automatic t_clear;
    int b;
    bit ok;
    send(16'h8800);
    send(16'h9055);
    b = log_n;
    send(16'h9900);
    clk_n(40);
    chk("R9", "fill count", log_n - b, 30);
    ok = 1;
    for (int i = 0; i < 30; i++)
      if (log_sel[b+i] != 2'd0 || log_data[b+i] != 8'h20 ||
          log_addr[b+i] != 8'((i / 10) * 16 + i % 10)) ok = 0;
    chk("R9", "fill order and data", ok, 1);
    chk("R9", "addr and incr after clear", {addr, incr}, {8'h00, 1'b1});
    ticks(109);
    chk("R10", "busy before clear ticks end", busy, 1);
    ticks(1);
    chk("R10", "busy after clear ticks", busy, 0);
    wr(8'h61);
    chk("R9", "char target after clear", {log_sel[b+30], log_addr[b+30]}, {2'd0, 8'h00});
  endtask

  task automatic keyread(input logic [1:0] row, input bit expect_reply);
    logic [7:0] got, exp;
    int oe_bad;
    got = '0;
    oe_bad = 0;
    exp = expect_reply ? {2'b00, keys[row*6 +: 6]} : 8'h00;
    cs_n = 1'b0;
    clk_n(3);
    for (int i = 0; i < 8; i++) begin
      sdi = (8'hA4 | row) >> (7 - i);
      sclk = 1'b0; clk_n(3);
      if (sdo_oe) oe_bad++;
      sclk = 1'b1; clk_n(3);
    end
    for (int p = 8; p < 16; p++) begin
      sdi = 1'b0;
      sclk = 1'b0; clk_n(3);
      got[15-p] = sdo;
      if (sdo_oe != expect_reply) oe_bad++;
      sclk = 1'b1; clk_n(3);
    end
    sclk = 1'b0; clk_n(3);
    cs_n = 1'b1; clk_n(6);
    chk("R4", "reply byte", got, exp);
    chk("R4", "drive enable window", oe_bad, 0);
    chk("R4", "released after frame", sdo_oe, 0);
  endtask

  task automatic t_keys;
    keyread(2'd2, 1'b1);
    keyread(2'd1, 1'b1);
    send(16'h9300);
    send(16'h9877);
    keyread(2'd3, 1'b0);
    ticks(7);
  endtask

  initial begin
    clk_n(3);
    rst_n = 1'b1;
    clk_n(2);
    t_reset();
    t_control();
    t_frame();
    t_write_mark_busy();
    t_char_and_wrap();
    t_shifts();
    t_busy_collision();
    t_clear();
    t_keys();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule